// File: doc/BRIEF.md
# Block-Streaming Read Address Unit

This unit sits between a requester that issues random 32-bit read addresses and a DRAM-style memory port. The requester's address does not choose which data comes back. Memory is read as 256-byte blocks, and each block is walked from its first byte as 32 consecutive 8-byte quadwords. When a block is used up, the walk moves on to a pseudo-random block.

The next block is picked by a 32-bit mixing register. Every completed read XORs the requester's address into this register. Eight quadwords before the current block ends, the mixing register is frozen into a next-block register, and a one-cycle prefetch strobe announces that address so a memory system can fetch it early.

Only one read is in flight at a time. A load strobe sets the starting block before a run begins. A synchronous active-low reset clears all pointers.

Top module: `qsau_top`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `mem_req_valid_o`, `rsp_valid_o` and `pf_valid_o` are 0. The read pointer, the mixing register and the next-block register are all zero, so the first read after reset goes to byte address 0.
- R2: A one-cycle `load_i` pulse sets the read pointer to `load_addr_i` with bits [7:0] forced to zero. The same pulse clears the mixing register and the next-block register.
- R3: Each accepted request (`req_valid_i` and `req_ready_o` both high at an edge) produces exactly one memory read at the current read pointer. The returned 64-bit data is presented on `rsp_data_o` with `rsp_valid_o` high for exactly one cycle, in the cycle after `mem_data_valid_i`. The request address never changes which memory address is read.
- R4: After a completed read whose pointer bits [7:0] are not 0xF8, the pointer advances by 8. A block is therefore read as 32 quadwords at offsets 0x00 through 0xF8.
- R5: Each completed read XORs the accepted request address into the 32-bit mixing register.
- R6: A completed read at pointer offset 0xC0 loads the next-block register with the mixing register value that already includes this read's address, with bits [7:0] cleared. In the same cycle that this register takes its new value, `pf_valid_o` is high for one cycle and `pf_addr_o` carries the new value. `pf_valid_o` is 0 after every other read.
- R7: After a completed read at offset 0xF8, the read pointer takes the value of the next-block register.
- R8: `req_ready_o` is 0 from the cycle after a request is accepted until the cycle after its memory data returns. A `req_valid_i` raised during that time is ignored and does not enter the mixing register.
- R9: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, `mem_req_valid_o` stays high and `mem_rd_addr_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load the starting block and clear the mixing and next-block registers |
| load_addr_i | input | 32 | Starting byte address; bits [7:0] are ignored |
| req_valid_i | input | 1 | Read request present |
| req_addr_i | input | 32 | Request address, used only for mixing |
| req_ready_o | output | 1 | Unit can accept a request |
| mem_req_valid_o | output | 1 | Memory read address valid |
| mem_rd_addr_o | output | 32 | Memory byte address, 8-byte aligned |
| mem_req_ready_i | input | 1 | Memory accepts the read address |
| mem_data_valid_i | input | 1 | Memory read data valid |
| mem_data_i | input | 64 | Memory read data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_data_o | output | 64 | Response quadword |
| pf_valid_o | output | 1 | One-cycle next-block prefetch strobe |
| pf_addr_o | output | 32 | Next-block address, 256-byte aligned |

## Verification
The assertions assume that memory returns data only for an address it has already accepted, and that it never raises `mem_data_valid_i` before then. They also assume that `load_i` is pulsed only while the unit is idle. The bench's memory model keeps to both rules: it raises data valid only after the address handshake has finished and a chosen gap has passed, and it loads only between reads. The bench also drives a decoy `req_valid_i` during every busy window. This tests that the unit ignores it, without breaking either assumption.

// File: rtl/qsau_pkg.sv
// Shared definitions for the block-streaming read address unit.
// Assumes byte addressing and power-of-two block and word sizes.
package qsau_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } qsau_state_e;
endpackage

// File: rtl/qsau_ctrl.sv
// Handshake sequencer. It accepts one request, issues one memory read, waits
// for the data and returns it as a one-cycle response. Assumes memory returns
// data only after it has accepted the address, and load_i only while idle.
module qsau_ctrl
    import qsau_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    input  logic              mem_data_valid_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              beat_done_o,
    output logic [ADDR_W-1:0] beat_addr_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o
);
    qsau_state_e state_q;

    assign req_ready_o     = (state_q == ST_IDLE);
    assign mem_req_valid_o = (state_q == ST_ISSUE);
    assign beat_done_o     = (state_q == ST_WAIT) && mem_data_valid_i;

    // Sequence idle -> issue -> wait -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (req_valid_i)      state_q <= ST_ISSUE;
                ST_ISSUE: if (mem_req_ready_i)  state_q <= ST_WAIT;
                ST_WAIT:  if (mem_data_valid_i) state_q <= ST_IDLE;
                default:                        state_q <= ST_IDLE;
            endcase
        end
    end

    // Hold the accepted request address for mixing at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_addr_o <= '0;
        end else if (req_ready_o && req_valid_i && !load_i) begin
            beat_addr_o <= req_addr_i;
        end
    end

    // Register the returned quadword as a one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            rsp_valid_o <= beat_done_o && !load_i;
            if (beat_done_o) rsp_data_o <= mem_data_i;
        end
    end
endmodule

// File: rtl/qsau_ptr.sv
// Read pointer. It steps through a block one word at a time and, after the
// last word, jumps to the next-block address. Assumes the next-block value is
// block aligned.
module qsau_ptr #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 256,
    parameter int WORD_BYTES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              beat_done_i,
    input  logic [ADDR_W-1:0] next_blk_i,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam int OFS_W = $clog2(BLOCK_BYTES);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(BLOCK_BYTES - WORD_BYTES);

    logic at_last;
    assign at_last = (ptr_o[OFS_W-1:0] == LAST_OFS);

    // Load, step by one word, or jump at the end of a block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else if (load_i) begin
            ptr_o <= {load_addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        end else if (beat_done_i) begin
            ptr_o <= at_last ? next_blk_i : ptr_o + ADDR_W'(WORD_BYTES);
        end
    end
endmodule

// File: rtl/qsau_mix.sv
// Mixing register and next-block register. Every completed read folds the
// request address into the mixing register. At the trigger offset, the mixed
// value is frozen as the next block and announced by a prefetch strobe.
module qsau_mix #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 256,
    parameter int WORD_BYTES  = 8,
    parameter int LEAD_WORDS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              beat_done_i,
    input  logic [ADDR_W-1:0] beat_addr_i,
    input  logic [ADDR_W-1:0] ptr_i,
    output logic [ADDR_W-1:0] next_blk_o,
    output logic              pf_valid_o
);
    localparam int OFS_W = $clog2(BLOCK_BYTES);
    localparam logic [OFS_W-1:0] TRIG_OFS =
        OFS_W'(BLOCK_BYTES - LEAD_WORDS * WORD_BYTES);

    logic [ADDR_W-1:0] mix_q;
    logic [ADDR_W-1:0] mix_next;
    logic              trig;

    assign mix_next = mix_q ^ beat_addr_i;
    assign trig     = beat_done_i && (ptr_i[OFS_W-1:0] == TRIG_OFS);

    // Accumulate request addresses into the mixing register.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) mix_q <= '0;
        else if (beat_done_i) mix_q <= mix_next;
    end

    // Freeze the next block at the trigger and pulse the prefetch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            next_blk_o <= '0;
            pf_valid_o <= 1'b0;
        end else begin
            pf_valid_o <= trig;
            if (trig) next_blk_o <= {mix_next[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        end
    end
endmodule

// File: rtl/qsau_top.sv
// Block-streaming read address unit. It turns random read requests into
// sequential block walks with pseudo-random jumps between blocks. Assumes one
// read in flight and a load only while idle.
module qsau_top #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int BLOCK_BYTES = 256,
    parameter int WORD_BYTES  = 8,
    parameter int LEAD_WORDS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    output logic              mem_req_valid_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic              mem_req_ready_i,
    input  logic              mem_data_valid_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              pf_valid_o,
    output logic [ADDR_W-1:0] pf_addr_o
);
    logic              beat_done;
    logic [ADDR_W-1:0] beat_addr;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] next_blk;

    qsau_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_i(load_i),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .req_ready_o(req_ready_o), .mem_req_valid_o(mem_req_valid_o),
        .mem_req_ready_i(mem_req_ready_i), .mem_data_valid_i(mem_data_valid_i),
        .mem_data_i(mem_data_i), .beat_done_o(beat_done),
        .beat_addr_o(beat_addr), .rsp_valid_o(rsp_valid_o),
        .rsp_data_o(rsp_data_o)
    );

    qsau_ptr #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES),
               .WORD_BYTES(WORD_BYTES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
        .beat_done_i(beat_done), .next_blk_i(next_blk), .ptr_o(ptr)
    );

    qsau_mix #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES),
               .WORD_BYTES(WORD_BYTES), .LEAD_WORDS(LEAD_WORDS)) u_mix (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .beat_done_i(beat_done),
        .beat_addr_i(beat_addr), .ptr_i(ptr), .next_blk_o(next_blk),
        .pf_valid_o(pf_valid_o)
    );

    assign mem_rd_addr_o = ptr;
    assign pf_addr_o     = next_blk;
endmodule

// File: rtl/qsau_chk.sv
// Port-level protocol checks for qsau_top. Assumes memory data arrives only
// after the address handshake has finished.
module qsau_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready_o,
    input logic              mem_req_valid_o,
    input logic [ADDR_W-1:0] mem_rd_addr_o,
    input logic              mem_req_ready_i,
    input logic              mem_data_valid_i,
    input logic              rsp_valid_o,
    input logic              pf_valid_o,
    input logic [ADDR_W-1:0] pf_addr_o
);
    // R8: no new request is accepted while a read is being issued
    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> !req_ready_o);

    // R9: an unaccepted memory read holds its address
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=>
            (mem_req_valid_o && $stable(mem_rd_addr_o)));

    // R4: memory addresses are word aligned
    p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (mem_rd_addr_o[2:0] == 3'd0));

    // R3: a response follows returned memory data
    p_rsp_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(mem_data_valid_i));

    // R3: response is a single-cycle pulse
    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

    // R6: prefetch strobe is one cycle with a block-aligned address
    p_pf_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid_o |-> (pf_addr_o[7:0] == 8'd0));
    p_pf_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid_o |=> !pf_valid_o);

    // R6: prefetch strobe appears only together with a response
    p_pf_with_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid_o |-> rsp_valid_o);
endmodule

bind qsau_top qsau_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qsau_chk (
    .clk(clk), .rst_n(rst_n), .req_ready_o(req_ready_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_rd_addr_o(mem_rd_addr_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_data_valid_i(mem_data_valid_i),
    .rsp_valid_o(rsp_valid_o), .pf_valid_o(pf_valid_o), .pf_addr_o(pf_addr_o)
);

// File: tb/qsau_top_test.sv
// Self-checking bench for qsau_top. A reference model of the pointer, the
// mixing register and the next-block register predicts every memory address,
// every response and every prefetch strobe.
module qsau_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] load_addr_i = '0;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic        req_ready_o;
    logic        mem_req_valid_o;
    logic [31:0] mem_rd_addr_o;
    logic        mem_req_ready_i = 1'b0;
    logic        mem_data_valid_i = 1'b0;
    logic [63:0] mem_data_i = '0;
    logic        rsp_valid_o;
    logic [63:0] rsp_data_o;
    logic        pf_valid_o;
    logic [31:0] pf_addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] m_ptr = '0, m_nxt = '0, m_mix = '0, lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    qsau_top uut (.*);

    function automatic logic [63:0] memf(input logic [31:0] a);
        return {a ^ 32'hA5A5_0000, ~a};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full read: handshake, memory model, response and model update.
    task automatic do_read(input logic [31:0] a, input int gap1, input int gap2);
        bit trig;
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_valid_i = 1'b1; req_addr_i = a;
        @(negedge clk);
        req_valid_i = 1'b1; req_addr_i = ~a;   // decoy while busy (R8)
        chk(mem_req_valid_o == 1'b1, "R3 read issued", 64'(mem_req_valid_o), 64'd1);
        chk(mem_rd_addr_o == m_ptr, "R3 R4 R7 read address", 64'(mem_rd_addr_o), 64'(m_ptr));
        for (int k = 0; k < gap1; k++) begin
            @(negedge clk);
            chk(mem_req_valid_o && mem_rd_addr_o == m_ptr, "R9 address held",
                64'(mem_rd_addr_o), 64'(m_ptr));
            chk(req_ready_o == 1'b0, "R8 busy not ready", 64'(req_ready_o), 64'd0);
        end
        mem_req_ready_i = 1'b1;
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        for (int k = 0; k < gap2; k++) begin
            chk(req_ready_o == 1'b0 && rsp_valid_o == 1'b0, "R8 waiting for data",
                64'(req_ready_o), 64'd0);
            @(negedge clk);
        end
        mem_data_valid_i = 1'b1; mem_data_i = memf(m_ptr);
        @(negedge clk);
        mem_data_valid_i = 1'b0; req_valid_i = 1'b0;
        chk(rsp_valid_o == 1'b1, "R3 response pulse", 64'(rsp_valid_o), 64'd1);
        chk(rsp_data_o == memf(m_ptr), "R3 response data", rsp_data_o, memf(m_ptr));
        chk(req_ready_o == 1'b1, "R8 ready after data", 64'(req_ready_o), 64'd1);
        // reference model
        m_mix = m_mix ^ a;                     // R5
        trig = (m_ptr[7:0] == 8'hC0);
        if (trig) m_nxt = {m_mix[31:8], 8'h00};
        chk(pf_valid_o == trig, "R6 prefetch strobe", 64'(pf_valid_o), 64'(trig));
        if (trig)
            chk(pf_addr_o == m_nxt, "R5 R6 prefetch address", 64'(pf_addr_o), 64'(m_nxt));
        if (m_ptr[7:0] == 8'hF8) m_ptr = m_nxt;  // R7
        else m_ptr = m_ptr + 32'd8;             // R4
        @(negedge clk);
        chk(rsp_valid_o == 1'b0, "R3 single-cycle response", 64'(rsp_valid_o), 64'd0);
    endtask

    task automatic run_reads(input int n);
        for (int i = 0; i < n; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            do_read(lcg, i % 3, (i / 3) % 3);
        end
    endtask

    task automatic do_load(input logic [31:0] a);
        @(negedge clk);
        load_i = 1'b1; load_addr_i = a;
        @(negedge clk);
        load_i = 1'b0;
        m_ptr = {a[31:8], 8'h00}; m_nxt = '0; m_mix = '0;   // R2
    endtask

    task automatic reset_unit();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ptr = '0; m_nxt = '0; m_mix = '0;
        chk(req_ready_o == 1'b1, "R1 ready after reset", 64'(req_ready_o), 64'd1);
        chk(!mem_req_valid_o && !rsp_valid_o && !pf_valid_o, "R1 outputs idle",
            {61'd0, mem_req_valid_o, rsp_valid_o, pf_valid_o}, 64'd0);
    endtask

    initial begin
        reset_unit();
        run_reads(40);              // R1 first read at 0, block crossing
        do_load(32'h1234_56A7);     // R2 low byte cleared
        run_reads(70);
        do_load(32'hFFFF_FF00);     // block at top of address space
        run_reads(36);
        reset_unit();               // R1 reset after activity
        run_reads(34);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule